// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the digital front end of a small byte-wide serial memory on a two-wire bus. It samples the clock and data lines on a fast system clock and finds Start and Stop conditions. It shifts bytes in and out most significant bit first, and it pulls the data line low through an open-drain enable, both for acknowledges and for read data. The memory behind it holds 512 or 1,024 bytes, chosen by a parameter. The top memory address bits travel inside the slave address byte, so only part of that byte is compared against the strap inputs.

A bus master reaches the memory in three ways. It can write one byte or a run of bytes within a 16-byte page. It can read from the internal address counter without sending an address. It can also set an address in write mode, send a repeated Start and then read. Reads continue for as long as the master acknowledges each byte. Every accepted write byte also goes to a separate write-cycle controller as a one-cycle strobe with address and data. While that controller reports busy, the slave refuses its address, so the master can poll until the write is done.

Top module: `ee_i2c_slave`

## Requirements
- R1: After reset the data-line enable is low, the address counter is 0 and every memory location reads 0xFF.
- R2: A slave address byte is acknowledged only when its bits 7..4 are 1010 and its strap field matches `strap_i`. The strap field is bits 3..2 against `strap_i[1:0]` for the 512-byte build, and bit 3 against `strap_i[0]` for the 1,024-byte build. On a mismatch the slave leaves the line released and ignores every further byte until the next Start.
- R3: An SDA fall while SCL is high (Start) restarts address decoding from any state, including a repeated Start in the middle of a transfer.
- R4: An SDA rise while SCL is high (Stop) releases the data line and returns the slave to idle. An address set before the Stop stays in the counter.
- R5: In write mode (bit 0 = 0), the embedded address bits form the upper memory address. These are bit 1 for the 512-byte build and bits 2..1 for the 1,024-byte build. The next byte gives address bits 7..0. Each data byte after that is acknowledged and stored, and it is presented once on `wr_strobe_o` with `wr_addr_o` and `wr_data_o`.
- R6: Successive data bytes in one write go to consecutive addresses. Only the low 4 address bits advance, so the address wraps inside its 16-byte page.
- R7: In a read-mode address byte (bit 0 = 1), the embedded address bits are ignored. After a write-mode address and word address followed by a repeated Start, the read returns the byte at the address that was set.
- R8: The address counter holds the last accessed address plus one. It persists across Stop, and a read with no word address starts from it.
- R9: A read sends successive bytes while the master acknowledges. The address wraps from the last location of the array to 0. After a master NACK the slave releases the line and ignores the bus until the next Start.
- R10: While `wr_busy_i` is high, a matching slave address byte is not acknowledged.
- R11: Input bits are taken at SCL rise. Driven bits and acknowledges change only while SCL is low, after a fall. The ninth clock of each byte is the acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 11-ADDR_W | Hardware-strapped slave address bits |
| wr_busy_i | input | 1 | Write-cycle controller is committing data |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| wr_strobe_o | output | 1 | One-cycle pulse per accepted write byte |
| wr_addr_o | output | ADDR_W | Address of the accepted write byte |
| wr_data_o | output | 8 | Accepted write byte |

## Verification
The bench places two slaves on one shared bus. One is built with ADDR_W=9 and strap 01, the other with ADDR_W=10 and strap 1. Every address byte is therefore decoded by both variants at once, and a fault in the partial compare shows up as a wrong acknowledge or a collision. The 1,024-byte build makes the two embedded address bits and the wrap from 0x3FF to 0 reachable. The 512-byte build covers the two-bit strap compare and the page wrap with the single embedded bit.

// File: rtl/ee_i2c_pkg.sv
package ee_i2c_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } ee_state_e;

endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic scl_m;
        logic scl_s;
        logic scl_p;
        logic sda_m;
        logic sda_s;
        logic sda_p;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.scl_m = scl_i;
        sync_d.scl_s = sync_q.scl_m;
        sync_d.scl_p = sync_q.scl_s;
        sync_d.sda_m = sda_i;
        sync_d.sda_s = sync_q.sda_m;
        sync_d.sda_p = sync_q.sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_o      = sync_q.scl_s;
    assign sda_o      = sync_q.sda_s;
    assign scl_rise_o = sync_q.scl_s & ~sync_q.scl_p;
    assign scl_fall_o = ~sync_q.scl_s & sync_q.scl_p;
    assign start_o    = sync_q.scl_s & sync_q.scl_p & sync_q.sda_p & ~sync_q.sda_s;
    assign stop_o     = sync_q.scl_s & sync_q.scl_p & ~sync_q.sda_p & sync_q.sda_s;

endmodule

// File: rtl/ee_mem_array.sv
module ee_mem_array #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cell_q [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= 8'hFF;
            end
            rdata_q <= 8'hFF;
        end else begin
            if (we_i) begin
                cell_q[waddr_i] <= wdata_i;
            end
            rdata_q <= cell_q[raddr_i];
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/ee_proto.sv
module ee_proto
    import ee_i2c_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s_i,
    input  logic              sda_s_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [10-ADDR_W:0] strap_i,
    input  logic              busy_i,
    input  logic [7:0]        rd_data_i,
    output logic              sda_oe_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [7:0]        wdata_o
);

    localparam int HI_W    = ADDR_W - 8;
    localparam int STRAP_W = 11 - ADDR_W;

    typedef struct packed {
        ee_state_e          st;
        logic [3:0]         cnt;
        logic [7:0]         sh;
        logic [7:0]         tx;
        logic [ADDR_W-1:0]  ctr;
        logic [HI_W-1:0]    hi;
        logic               rw;
        logic               mnack;
        logic               oe;
        logic               we;
        logic [ADDR_W-1:0]  waddr;
        logic [7:0]         wdata;
    } proto_t;

    proto_t q, n;
    logic   addr_hit;

    assign addr_hit = (q.sh[7:4] == DEV_TYPE)
                    && (q.sh[3 -: STRAP_W] == strap_i)
                    && !busy_i;

    always_comb begin
        logic rd_load;
        rd_load = 1'b0;
        n       = q;
        n.we    = 1'b0;
        if (start_i) begin
            n.st  = ST_DEV;
            n.cnt = '0;
            n.oe  = 1'b0;
        end else if (stop_i) begin
            n.st  = ST_IDLE;
            n.cnt = '0;
            n.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise_i && q.cnt != 4'd8) begin
                        n.sh  = {q.sh[6:0], sda_s_i};
                        n.cnt = q.cnt + 4'd1;
                    end else if (scl_fall_i && q.cnt == 4'd8) begin
                        n.cnt = '0;
                        if (q.st == ST_DEV) begin
                            if (addr_hit) begin
                                n.oe = 1'b1;
                                n.rw = q.sh[0];
                                if (!q.sh[0]) begin
                                    n.hi = q.sh[HI_W:1];
                                end
                                n.st = ST_DEV_ACK;
                            end else begin
                                n.st = ST_IDLE;
                            end
                        end else if (q.st == ST_WADDR) begin
                            n.ctr = {q.hi, q.sh};
                            n.oe  = 1'b1;
                            n.st  = ST_WADDR_ACK;
                        end else begin
                            n.we    = 1'b1;
                            n.waddr = q.ctr;
                            n.wdata = q.sh;
                            n.ctr   = {q.ctr[ADDR_W-1:PAGE_W], q.ctr[PAGE_W-1:0] + 1'b1};
                            n.oe    = 1'b1;
                            n.st    = ST_WDATA_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall_i) begin
                        if (q.rw) begin
                            rd_load = 1'b1;
                        end else begin
                            n.oe  = 1'b0;
                            n.cnt = '0;
                            n.st  = ST_WADDR;
                        end
                    end
                end
                ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall_i) begin
                        n.oe  = 1'b0;
                        n.cnt = '0;
                        n.st  = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall_i) begin
                        if (q.cnt == 4'd8) begin
                            n.oe = 1'b0;
                            n.st = ST_RACK;
                        end else begin
                            n.tx  = {q.tx[6:0], 1'b0};
                            n.oe  = ~q.tx[6];
                            n.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise_i) begin
                        n.mnack = sda_s_i;
                    end else if (scl_fall_i) begin
                        if (!q.mnack) begin
                            rd_load = 1'b1;
                        end else begin
                            n.oe = 1'b0;
                            n.st = ST_IDLE;
                        end
                    end
                end
                default: begin
                    n.st = ST_IDLE;
                    n.oe = 1'b0;
                end
            endcase
            if (rd_load) begin
                n.tx  = rd_data_i;
                n.oe  = ~rd_data_i[7];
                n.ctr = q.ctr + 1'b1;
                n.cnt = 4'd1;
                n.st  = ST_RDATA;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    assign sda_oe_o  = q.oe;
    assign rd_addr_o = q.ctr;
    assign we_o      = q.we;
    assign waddr_o   = q.waddr;
    assign wdata_o   = q.wdata;

    // R3: a Start always restarts decoding with the line released
    a_r3_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (q.st == ST_DEV && q.cnt == 4'd0 && !sda_oe_o));

    // R4: a Stop releases the line and idles
    a_r4_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!sda_oe_o && q.st == ST_IDLE));

    // R10: busy turns a slave address into a NACK
    a_r10_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DEV && scl_fall_i && q.cnt == 4'd8 && busy_i && !start_i && !stop_i)
        |=> (!sda_oe_o && q.st == ST_IDLE));

    // R6: the counter after a write stays in the page of the written byte
    a_r6_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |-> (q.ctr[ADDR_W-1:PAGE_W] == q.waddr[ADDR_W-1:PAGE_W]));

    // R2: the address acknowledge starts only for the fixed type field
    a_r2_type_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) && q.st == ST_DEV_ACK) |-> (q.sh[7:4] == DEV_TYPE));

    // R11: the driven level changes only while SCL is low
    a_r11_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start_i) && !$past(stop_i) && sda_oe_o != $past(sda_oe_o)) |-> !scl_s_i);

endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [10-ADDR_W:0] strap_i,
    input  logic               wr_busy_i,
    output logic               sda_oe_o,
    output logic               wr_strobe_o,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic [7:0]         wr_data_o
);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [7:0]        rd_data;
    logic [ADDR_W-1:0] rd_addr;

    ee_line_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    ee_proto #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_proto (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s_i    (scl_s),
        .sda_s_i    (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_ev),
        .stop_i     (stop_ev),
        .strap_i    (strap_i),
        .busy_i     (wr_busy_i),
        .rd_data_i  (rd_data),
        .sda_oe_o   (sda_oe_o),
        .rd_addr_o  (rd_addr),
        .we_o       (wr_strobe_o),
        .waddr_o    (wr_addr_o),
        .wdata_o    (wr_data_o)
    );

    ee_mem_array #(
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_strobe_o),
        .waddr_i (wr_addr_o),
        .wdata_i (wr_data_o),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

endmodule

// File: tb/ee_i2c_slave_tb_top.sv
module ee_i2c_slave_tb_top;

    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy_s = 1'b0;
    logic busy_b = 1'b0;
    logic sda_line;
    logic oe_s, oe_b, stb_s, stb_b;
    logic [8:0] wa_s;
    logic [9:0] wa_b;
    logic [7:0] wd_s, wd_b;

    int checks = 0;
    int errors = 0;
    int mem_m [2][1024];
    int ctr_m [2];
    bit busy_m [2];
    int exp_s [$];
    int exp_b [$];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~oe_s & ~oe_b;

    ee_i2c_slave #(.ADDR_W(10)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .strap_i(1'b1), .wr_busy_i(busy_b), .sda_oe_o(oe_b),
        .wr_strobe_o(stb_b), .wr_addr_o(wa_b), .wr_data_o(wd_b)
    );

    ee_i2c_slave #(.ADDR_W(9)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .strap_i(2'b01), .wr_busy_i(busy_s), .sda_oe_o(oe_s),
        .wr_strobe_o(stb_s), .wr_addr_o(wa_s), .wr_data_o(wd_s)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // model: 0 = 512-byte slave (strap 01), 1 = 1,024-byte slave (strap 1)
    function automatic int target(int b);
        if (((b >> 4) & 15) != 10) return -1;
        if (((b >> 3) & 1) == 1) return 1;
        if (((b >> 2) & 3) == 1) return 0;
        return -1;
    endfunction

    function automatic int msize(int t);
        return (t == 1) ? 1024 : 512;
    endfunction

    task automatic tick(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(2*Q);
        end
        sda_m = 1'b0; tick(2*Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(2*Q); sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic bit_io(bit b, output bit seen);
        tick(Q); sda_m = b; tick(Q); scl_m = 1'b1; tick(Q);
        seen = sda_line;
        tick(Q); scl_m = 1'b0;
    endtask

    task automatic byte_out(int b, bit exp_ack, string tag);
        bit s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        check(s == !exp_ack, tag, s, !exp_ack);
    endtask

    task automatic byte_in(bit nack, int exp, string tag);
        bit s;
        int d;
        d = 0;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            d = (d << 1) | s;
        end
        bit_io(nack, s);
        check(d == exp, tag, d, exp);
    endtask

    task automatic set_addr(int dev, int wa, string tag);
        int t;
        bus_start();
        t = target(dev);
        byte_out(dev, t >= 0 && !busy_m[t], tag);
        byte_out(wa, 1'b1, tag);
        ctr_m[t] = (t == 0) ? (((dev >> 1) & 1) * 256 + wa) : (((dev >> 1) & 3) * 256 + wa);
    endtask

    task automatic write_txn(int dev, int wa, int data [$], string tag);
        int t, a;
        bus_start();
        t = target(dev);
        byte_out(dev, t >= 0 && !busy_m[t], tag);
        if (t < 0 || busy_m[t]) begin
            bus_stop();
            return;
        end
        byte_out(wa, 1'b1, tag);
        ctr_m[t] = (t == 0) ? (((dev >> 1) & 1) * 256 + wa) : (((dev >> 1) & 3) * 256 + wa);
        foreach (data[k]) begin
            a = ctr_m[t];
            if (t == 0) exp_s.push_back(a * 256 + data[k]);
            else        exp_b.push_back(a * 256 + data[k]);
            mem_m[t][a] = data[k];
            byte_out(data[k], 1'b1, tag);
            ctr_m[t] = (a & ~15) | ((a + 1) & 15);
        end
        bus_stop();
    endtask

    task automatic read_txn(int dev, int cnt, bit do_stop, string tag);
        int t, e;
        bus_start();
        t = target(dev);
        byte_out(dev, t >= 0 && !busy_m[t], tag);
        if (t < 0 || busy_m[t]) begin
            if (do_stop) bus_stop();
            return;
        end
        for (int k = 0; k < cnt; k++) begin
            e = mem_m[t][ctr_m[t]];
            ctr_m[t] = (ctr_m[t] + 1) % msize(t);
            byte_in(k == cnt - 1, e, tag);
        end
        if (do_stop) bus_stop();
    endtask

    // write hand-off monitor (R5)
    always @(negedge clk) begin
        if (rst_n) begin
            if (stb_s) begin
                if (exp_s.size() == 0) check(1'b0, "R5 small strobe", wa_s * 256 + wd_s, -1);
                else begin
                    int e;
                    e = exp_s.pop_front();
                    check(wa_s * 256 + wd_s == e, "R5 small strobe", wa_s * 256 + wd_s, e);
                end
            end
            if (stb_b) begin
                if (exp_b.size() == 0) check(1'b0, "R5 big strobe", wa_b * 256 + wd_b, -1);
                else begin
                    int e;
                    e = exp_b.pop_front();
                    check(wa_b * 256 + wd_b == e, "R5 big strobe", wa_b * 256 + wd_b, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int t = 0; t < 2; t++) begin
            for (int a = 0; a < 1024; a++) mem_m[t][a] = 'hFF;
            ctr_m[t] = 0;
            busy_m[t] = 1'b0;
        end
        tick(5);
        rst_n = 1'b1;
        tick(5);
        check(oe_s == 1'b0 && oe_b == 1'b0, "R1 reset release", {oe_s, oe_b}, 0);
        check(stb_s == 1'b0 && stb_b == 1'b0, "R1 reset strobe", {stb_s, stb_b}, 0);

        // R1 / R8: current-address reads from counter 0 after reset
        read_txn('hA5, 1, 1'b1, "R1 small fresh read");
        read_txn('hA9, 2, 1'b1, "R1 big fresh read");

        // R5: byte write with two embedded bits, 0x2A5
        write_txn('hAC, 'hA5, '{'h5C}, "R5 big byte write");
        // R7 / R3: random read, embedded bits in read byte differ
        set_addr('hAC, 'hA5, "R7 set");
        read_txn('hA9, 1, 1'b1, "R7 R11 random read");
        // R8: counter continues at 0x2A6
        read_txn('hAF, 1, 1'b1, "R8 current read");

        // R6: page write on small slave from 0x11C, six bytes
        write_txn('hA6, 'h1C, '{'h01, 'h02, 'h03, 'h04, 'h05, 'h06}, "R6 page write");
        set_addr('hA6, 'h10, "R6 set");
        read_txn('hA5, 3, 1'b1, "R6 wrapped bytes");
        set_addr('hA6, 'h1C, "R6 set2");
        read_txn('hA7, 4, 1'b1, "R6 page tail");

        // R4 / R8: address set then Stop; counter keeps the address
        set_addr('hA6, 'h02, "R4 set");
        bus_stop();
        check(oe_s == 1'b0 && oe_b == 1'b0, "R4 stop release", {oe_s, oe_b}, 0);
        read_txn('hA5, 1, 1'b1, "R4 R8 read after stop");

        // R9: sequential read wraps 0x3FF -> 0x000 on big slave
        write_txn('hAE, 'hFF, '{'h81}, "R9 prep hi");
        write_txn('hA8, 'h00, '{'h18}, "R9 prep lo");
        set_addr('hAE, 'hFE, "R9 set");
        read_txn('hA9, 3, 1'b0, "R9 wrap read");
        // after NACK the slave ignores bytes until Start
        byte_out('hA9, 1'b0, "R9 ignored after nack");
        bus_stop();

        // R2: mismatches and ignore-until-Start
        bus_start();
        byte_out('hB4, 1'b0, "R2 wrong type");
        byte_out('hA4, 1'b0, "R2 ignored without start");
        bus_stop();
        read_txn('hA1, 1, 1'b1, "R2 strap mismatch");
        write_txn('hA2, 'h33, '{'h44}, "R2 strap mismatch write");
        read_txn('hA5, 1, 1'b1, "R2 small match read");

        // R10: busy controller refuses the address
        busy_b = 1'b1; busy_m[1] = 1'b1;
        tick(2);
        write_txn('hA8, 'h10, '{'h99}, "R10 busy write");
        read_txn('hA9, 1, 1'b1, "R10 busy read");
        busy_b = 1'b0; busy_m[1] = 1'b0;
        tick(2);
        read_txn('hA9, 1, 1'b1, "R10 after busy");
        set_addr('hA8, 'h10, "R10 set");
        read_txn('hA9, 1, 1'b1, "R10 no write landed");

        tick(20);
        check(exp_s.size() == 0, "R5 small strobes all seen", exp_s.size(), 0);
        check(exp_b.size() == 0, "R5 big strobes all seen", exp_b.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule